// File: doc/BRIEF.md
# SMBus Block-Write Configuration Slave

This block is a two-wire serial slave that takes block-write transfers from an SMBus host. It stores the payload in a small bank of byte-wide configuration registers. Each register bit drives one enable line of a clock generator, so one host transfer can switch any set of outputs on or off. The registers load parameterised defaults at reset, so the enables are valid even if the host never writes.

The block samples SCL and SDA with its own system clock and finds start and stop conditions from the sampled lines. A transfer has a fixed shape: an address byte, a command byte, a count byte, and then the data bytes. The block acknowledges a byte by pulling SDA low through an open-drain enable. Data always fills the bank from register 0 upward. The host may end the transfer after any whole byte. No register changes until the count byte has been accepted.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `cfg_o` equals the `RST_VAL` parameter and `sda_oe_o` is low.
- R2: The address byte is acknowledged only when it equals `{ADDR7, 1'b0}`, which is D2h by default. A read request (bit 0 set) or any other address is not acknowledged and changes no register.
- R3: The byte after the address must equal `CMD_CODE` (00h by default). Any other value is not acknowledged and changes no register.
- R4: A count byte from 1 to `MAXCNT` (32 by default) is acknowledged. A count of 0 or above `MAXCNT` is not acknowledged and changes no register. A transfer that ends before the count byte is acknowledged changes no register.
- R5: Data bytes arrive most significant bit first and are acknowledged. Data byte k is written to register k, which drives `cfg_o[8k+7:8k]`. Writing starts at register 0 in every transfer.
- R6: A data byte whose position is at or beyond the count, or at or beyond `NREG`, is not acknowledged and is discarded. After any non-acknowledge, the block ignores the bus until the next start condition.
- R7: `sda_oe_o` is high for the whole ninth SCL clock of an accepted byte, is low for a rejected byte, and changes only while SCL is low.
- R8: A repeated start sends the block back to waiting for an address, and the next transfer again writes from register 0. After a stop, bytes already received completely stay committed. A byte cut short by a stop or a start is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial lines |
| rst_n | input | 1 | Active-low reset; loads register defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain acknowledge) |
| cfg_o | output | NREG*8 | Register bank contents; byte k holds the output enables of register k |

## Verification
A wrong protocol state shows up at the next ninth SCL clock. At that point the host sees an acknowledge where none is due, or no acknowledge where one is due. Because of this, the bench checks every acknowledge slot of every byte, and a wrong state is found within at most nine SCL clocks. A wrong data index or a write at the wrong time shows up as a byte of `cfg_o` that does not match the expected bank. So `cfg_o` is compared with an independent model after each transfer ends, including transfers cut short by a stop, by a repeated start, or by a non-acknowledge.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   // Protocol position inside a transfer
   typedef enum logic [2:0] {
      ST_IDLE,    // waiting for a start after reset or stop
      ST_ADDR,    // receiving the address byte
      ST_CMD,     // receiving the command byte
      ST_COUNT,   // receiving the byte count
      ST_DATA,    // receiving payload bytes
      ST_IGNORE   // rejected byte seen, wait for a new start
   } smb_st_e;

   // Bit-level phase of the current byte
   typedef enum logic [1:0] {
      PH_BITS,    // shifting in eight bits
      PH_ACKWAIT, // byte done, waiting for SCL to fall
      PH_ACKDRV   // ninth clock: drive or release SDA
   } smb_ph_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_block_fsm.sv
module smb_block_fsm
   import smb_cfg_pkg::*;
#(
   parameter int         NREG     = 8,
   parameter logic [6:0] ADDR7    = 7'h69,
   parameter logic [7:0] CMD_CODE = 8'h00,
   parameter int         MAXCNT   = 32,
   parameter int         IDXW     = 3,
   parameter int         CNTW     = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sda_s,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            start_det,
   input  logic            stop_det,
   output logic            sda_oe,
   output logic            wr_en,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output smb_st_e         st_o,
   output smb_ph_e         ph_o
);

   localparam logic [7:0]      ADDR_BYTE = {ADDR7, 1'b0};
   localparam logic [7:0]      MAXCNT_B  = 8'(MAXCNT);
   localparam logic [CNTW-1:0] NREG_C    = CNTW'(NREG);

   smb_st_e         st, nxt_q, nxt_c;
   smb_ph_e         ph;
   logic [2:0]      bitcnt;
   logic [7:0]      shreg;
   logic [7:0]      byte_w;
   logic            ack_q, acc_c;
   logic [CNTW-1:0] cnt_q;
   logic [CNTW-1:0] didx;
   logic            byte_done;

   assign byte_w    = {shreg[6:0], sda_s};
   assign byte_done = scl_rise && (ph == PH_BITS) && (bitcnt == 3'd7);

   // Accept / reject decision for the byte completing this cycle
   always_comb begin
      acc_c = 1'b0;
      nxt_c = ST_IGNORE;
      unique case (st)
         ST_ADDR: begin
            acc_c = (byte_w == ADDR_BYTE);
            nxt_c = ST_CMD;
         end
         ST_CMD: begin
            acc_c = (byte_w == CMD_CODE);
            nxt_c = ST_COUNT;
         end
         ST_COUNT: begin
            acc_c = (byte_w != 8'd0) && (byte_w <= MAXCNT_B);
            nxt_c = ST_DATA;
         end
         ST_DATA: begin
            acc_c = (didx < cnt_q) && (didx < NREG_C);
            nxt_c = ST_DATA;
         end
         default: begin
            acc_c = 1'b0;
            nxt_c = ST_IGNORE;
         end
      endcase
      if (!acc_c) nxt_c = ST_IGNORE;
   end

   assign wr_en   = byte_done && (st == ST_DATA) && acc_c;
   assign wr_idx  = didx[IDXW-1:0];
   assign wr_data = byte_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         nxt_q  <= ST_IDLE;
         ph     <= PH_BITS;
         bitcnt <= '0;
         shreg  <= '0;
         ack_q  <= 1'b0;
         cnt_q  <= '0;
         didx   <= '0;
      end else if (start_det) begin
         st     <= ST_ADDR;
         ph     <= PH_BITS;
         bitcnt <= '0;
         didx   <= '0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         ph     <= PH_BITS;
         bitcnt <= '0;
      end else begin
         unique case (ph)
            PH_BITS: begin
               if (scl_rise && st != ST_IDLE && st != ST_IGNORE) begin
                  shreg <= byte_w;
                  if (bitcnt == 3'd7) begin
                     bitcnt <= '0;
                     ph     <= PH_ACKWAIT;
                     ack_q  <= acc_c;
                     nxt_q  <= nxt_c;
                     if (st == ST_COUNT && acc_c) cnt_q <= byte_w[CNTW-1:0];
                     if (wr_en) didx <= didx + 1'b1;
                  end else begin
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
            end
            PH_ACKWAIT: if (scl_fall) ph <= PH_ACKDRV;
            PH_ACKDRV: begin
               if (scl_fall) begin
                  ph <= PH_BITS;
                  st <= nxt_q;
               end
            end
            default: ph <= PH_BITS;
         endcase
      end
   end

   assign sda_oe = (ph == PH_ACKDRV) && ack_q;
   assign st_o   = st;
   assign ph_o   = ph;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
   parameter int                NREG    = 8,
   parameter int                IDXW    = 3,
   parameter logic [NREG*8-1:0] RST_VAL = {NREG{8'hFF}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDXW-1:0]   idx,
   input  logic [7:0]        wdata,
   output logic [NREG*8-1:0] cfg
);

   for (genvar i = 0; i < NREG; i++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       q <= RST_VAL[i*8 +: 8];
         else if (we && idx == IDXW'(i))   q <= wdata;
      end
      assign cfg[i*8 +: 8] = q;
   end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
   import smb_cfg_pkg::*;
#(
   parameter int                NREG        = 8,
   parameter logic [6:0]        ADDR7       = 7'h69,
   parameter logic [7:0]        CMD_CODE    = 8'h00,
   parameter int                MAXCNT      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] RST_VAL     = {NREG{8'hFF}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [NREG*8-1:0] cfg_o
);

   localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int CNTW = $clog2(MAXCNT + 1);

   if (NREG < 1 || NREG > MAXCNT) begin : g_bad_nreg
      $error("NREG must lie between 1 and MAXCNT");
   end
   if (MAXCNT < 1 || MAXCNT > 255) begin : g_bad_maxcnt
      $error("MAXCNT must fit a count byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic            sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [7:0]      wr_data;
   smb_st_e         st;
   smb_ph_e         ph;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_block_fsm #(
      .NREG     (NREG),
      .ADDR7    (ADDR7),
      .CMD_CODE (CMD_CODE),
      .MAXCNT   (MAXCNT),
      .IDXW     (IDXW),
      .CNTW     (CNTW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe_o),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .st_o      (st),
      .ph_o      (ph)
   );

   smb_cfg_bank #(
      .NREG    (NREG),
      .IDXW    (IDXW),
      .RST_VAL (RST_VAL)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .idx   (wr_idx),
      .wdata (wr_data),
      .cfg   (cfg_o)
   );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
   import smb_cfg_pkg::*;
#(
   parameter int NREG = 8,
   parameter int IDXW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              start_det,
   input logic              stop_det,
   input smb_st_e           st,
   input smb_ph_e           ph,
   input logic              wr_en,
   input logic [IDXW-1:0]   wr_idx,
   input logic [NREG*8-1:0] cfg_o
);

   // Acknowledge drive may only move while the bus clock is low
   p_oe_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // A start always leads to address reception
   p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_ADDR));

   // A stop returns to idle with SDA released
   p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE && !sda_oe));

   // Writes never address a register outside the bank
   p_wr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NREG));

   // Register contents only change after a bank write
   p_cfg_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_o) |-> $past(wr_en));

   // Writes happen only once the count byte was accepted
   p_wr_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (st == ST_DATA && ph == PH_BITS));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe_o),
   .start_det (start_det),
   .stop_det  (stop_det),
   .st        (st),
   .ph        (ph),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .cfg_o     (cfg_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

   localparam int          CLK_PERIOD = 10;
   localparam int          NREG       = 8;
   localparam int          QCYC       = 5;
   localparam logic [63:0] DEF        = 64'h0F_C3_A5_3C_FF_00_7E_81;
   localparam int          NVEC       = 10;
   // {address byte, command, count, bytes the host sends}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'hD2, 8'h00, 8'd4,  8'd4},
      {8'hD2, 8'h00, 8'd8,  8'd8},
      {8'hD4, 8'h00, 8'd2,  8'd2},
      {8'hD3, 8'h00, 8'd2,  8'd2},
      {8'hD2, 8'h01, 8'd2,  8'd2},
      {8'hD2, 8'h00, 8'd0,  8'd1},
      {8'hD2, 8'h00, 8'd33, 8'd1},
      {8'hD2, 8'h00, 8'd32, 8'd10},
      {8'hD2, 8'h00, 8'd5,  8'd3},
      {8'hD2, 8'h00, 8'd2,  8'd4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_drv = 1'b1;
   logic sda_oe;
   logic [NREG*8-1:0] cfg;
   wire  sda_bus = sda_drv & ~sda_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [63:0] model;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_cfg_slave #(.NREG(NREG), .RST_VAL(DEF)) i_smb_cfg_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .sda_oe_o (sda_oe),
      .cfg_o    (cfg)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (QCYC) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; scl = 1'b1; wq();
      sda_drv = 1'b0; wq();
      scl = 1'b0; wq();
   endtask

   task automatic bus_rstart();
      sda_drv = 1'b1; wq();
      scl = 1'b1; wq();
      sda_drv = 1'b0; wq();
      scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wq();
      scl = 1'b1; wq();
      sda_drv = 1'b1; wq(); wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; wq();
         scl = 1'b1; wq(); wq();
         scl = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      sda_drv = 1'b1; wq();
      scl = 1'b1; wq();
      acked = !sda_bus;
      wq();
      scl = 1'b0; wq();
   endtask

   task automatic send_exp(input logic [7:0] b, input bit e, input string tag, output bit ak);
      send_byte(b, ak);
      check(ak == e, tag, 64'(ak), 64'(e));
   endtask

   task automatic run_xfer(input int v, input logic [7:0] adr, input logic [7:0] cmd,
                           input logic [7:0] cnt, input logic [7:0] nsend);
      bit ak, e;
      logic [7:0] dat;
      bus_start();
      e = (adr == 8'hD2);
      send_exp(adr, e, "R2 address", ak);
      if (ak && e) begin
         e = (cmd == 8'h00);
         send_exp(cmd, e, "R3 command", ak);
      end
      if (ak && e) begin
         e = (cnt != 8'd0) && (cnt <= 8'd32);
         send_exp(cnt, e, "R4 count", ak);
      end
      for (int k = 0; k < int'(nsend) && ak && e; k++) begin
         dat = 8'(((v * 16) ^ (k * 37)) ^ 165);
         e = (k < int'(cnt)) && (k < NREG);
         send_exp(dat, e, e ? "R5 R7 data ack" : "R6 data nack", ak);
         if (e) model[k*8 +: 8] = dat;
      end
      bus_stop();
      check(cfg == model, "R5 bank after transfer", cfg, model);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit ak;
      model = DEF;
      repeat (4) @(negedge clk);
      check(cfg == DEF, "R1 reset value", cfg, DEF);
      check(sda_oe == 1'b0, "R1 sda idle", 64'(sda_oe), 64'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(cfg == DEF, "R1 after release", cfg, DEF);

      // Table of transfers
      for (int v = 0; v < NVEC; v++)
         run_xfer(v, VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

      // Stop before the count byte: no change (R4)
      bus_start();
      send_exp(8'hD2, 1'b1, "R2 address", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      bus_stop();
      check(cfg == model, "R4 abort before count", cfg, model);

      // Count byte cut short by stop (R4)
      bus_start();
      send_exp(8'hD2, 1'b1, "R2 address", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      send_bits(8'h03, 4);
      scl = 1'b0;
      bus_stop();
      check(cfg == model, "R4 partial count", cfg, model);

      // Repeated start restarts at register 0 (R8)
      bus_start();
      send_exp(8'hD2, 1'b1, "R2 address", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      send_exp(8'd3,  1'b1, "R4 count", ak);
      send_exp(8'h11, 1'b1, "R5 data", ak);
      model[7:0] = 8'h11;
      bus_rstart();
      send_exp(8'hD2, 1'b1, "R8 address after restart", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      send_exp(8'd1,  1'b1, "R4 count", ak);
      send_exp(8'h22, 1'b1, "R8 data after restart", ak);
      model[7:0] = 8'h22;
      bus_stop();
      check(cfg == model, "R8 repeated start", cfg, model);

      // Partial data byte discarded, complete byte kept (R8)
      bus_start();
      send_exp(8'hD2, 1'b1, "R2 address", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      send_exp(8'd3,  1'b1, "R4 count", ak);
      send_exp(8'h33, 1'b1, "R5 data", ak);
      model[7:0] = 8'h33;
      send_bits(8'h5C, 5);
      bus_stop();
      check(cfg == model, "R8 partial byte", cfg, model);

      // After a rejected byte the bus is ignored (R6)
      bus_start();
      send_exp(8'hD2, 1'b1, "R2 address", ak);
      send_exp(8'h00, 1'b1, "R3 command", ak);
      send_exp(8'd1,  1'b1, "R4 count", ak);
      send_exp(8'h44, 1'b1, "R5 data", ak);
      model[7:0] = 8'h44;
      send_exp(8'h55, 1'b0, "R6 beyond count", ak);
      send_exp(8'h66, 1'b0, "R6 ignored after nack", ak);
      bus_stop();
      check(cfg == model, "R6 discarded bytes", cfg, model);

      // Reset again restores defaults (R1)
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(cfg == DEF, "R1 second reset", cfg, DEF);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule